// File: doc/BRIEF.md
# Carry Skip Adder with Zero-Carry Groups and Half-Adder Correction

This block is a purely combinational two-operand adder. It takes two words and a carry-in and produces a word-wide sum and a carry-out. The word is cut into equal ripple-carry groups. The lowest group adds its slice with the real carry-in. Every higher group adds its slice with its carry input held at zero, so all groups work at the same time. A short half-adder chain in each higher group then adds the carry arriving from below to that group's intermediate result.

The carries between groups travel along a skip chain of inverting gates. The chain alternates an AND-OR-invert cell with an OR-AND-invert cell. The carry therefore changes polarity at each stage. Each consumer restores the true polarity before it uses the carry. The longest path goes through the lowest ripple group, then along the skip chain, then through the half-adder chain of the top group.

There is no clock and no state, so the block has no states or transitions to name. Width and group size are parameters. The defaults give 32 bits in eight groups of four.

Top module: `carry_skip_adder`

## Requirements
- R1: `{cout, sum}` equals the full-width arithmetic value `a + b + cin`, with `cout` as bit WIDTH of that value.
- R2: Only the lowest group sees `cin`. With the operands held fixed, raising `cin` from 0 to 1 raises `{cout, sum}` by exactly one.
- R3: Each higher group first adds its slice with a zero carry. Its half-adder chain then gives a final slice equal to the intermediate slice plus the true incoming carry, modulo 2^GROUP.
- R4: A stage whose zero-carry group produces a carry-out passes a carry of 1 to the next stage, whatever carry it received.
- R5: A stage that does not generate, and whose intermediate slice is all ones, passes on the carry it received unchanged.
- R6: A stage that neither generates nor has an all-ones intermediate slice passes a carry of 0.
- R7: Adding all ones to zero with `cin` = 1 gives a sum of zero and `cout` = 1, because the carry runs through every group.
- R8: Two zero operands with `cin` = 0 give a sum of zero and `cout` = 0.
- R9: `cout` is in true polarity whether the last stage's skip cell is an AND-OR-invert cell (odd stage count minus one) or an OR-AND-invert cell.
- R10: Each ripple group produces `{carry, slice}` equal to its two operand slices plus its carry input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into the lowest group |
| sum | output | WIDTH | Sum, modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top group, true polarity |

## Verification
The immediate assertions inside the group, incrementer, skip and top modules assume that they run on settled, two-state inputs. A check on a half-settled value would only be comparing glitches. The bench therefore changes operands and carry-in only from its initial block, always to fully defined values. It then waits a fixed delay before it reads any output. It never drives X or Z. A stage count of two and a stage count of three are each swept over all operand values or nearly all of them. Together they cover a final skip cell of each polarity. The 32-bit default instance gets directed corner values and random words.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
package csa_pkg;

    // Polarity in which a stage's carry travels along the skip chain
    typedef enum logic {
        CARRY_TRUE = 1'b0,
        CARRY_INV  = 1'b1
    } carry_pol_e;

    // Stage 0 hands on a true carry; AOI cells (odd stages) invert,
    // OAI cells (even stages) restore.
    function automatic carry_pol_e stage_pol(input int stage);
        return (stage % 2 == 1) ? CARRY_INV : CARRY_TRUE;
    endfunction

endpackage

// File: rtl/csa_ripple_group.sv
`timescale 1ns/1ps
module csa_ripple_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         c_in,
    output logic [W-1:0] s,
    output logic         c_out
);

    logic [W:0] rip;

    assign rip[0] = c_in;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_fa
            logic half;
            assign half       = x[i] ^ y[i];
            assign s[i]       = half ^ rip[i];
            assign rip[i + 1] = (x[i] & y[i]) | (half & rip[i]);
        end
    endgenerate

    assign c_out = rip[W];

    always_comb begin
        AST_GROUP_SUM: assert ({c_out, s} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, c_in})); // R10
    end

endmodule

// File: rtl/csa_inc_chain.sv
`timescale 1ns/1ps
module csa_inc_chain #(
    parameter int W = 4
) (
    input  logic [W-1:0] d,
    input  logic         inc,
    output logic [W-1:0] q,
    output logic         all_set
);

    logic [W-1:0] hc;
    logic [W-1:0] acc;

    assign hc[0]  = inc;
    assign q[0]   = d[0] ^ hc[0];
    assign acc[0] = d[0];

    genvar i;
    generate
        for (i = 1; i < W; i++) begin : g_ha
            assign hc[i]  = d[i - 1] & hc[i - 1];
            assign q[i]   = d[i] ^ hc[i];
            assign acc[i] = acc[i - 1] & d[i];
        end
    endgenerate

    assign all_set = acc[W-1];

    always_comb begin
        AST_INC_RESULT: assert (q == d + {{(W-1){1'b0}}, inc}); // R3
    end

endmodule

// File: rtl/csa_skip_cell.sv
`timescale 1ns/1ps
module csa_skip_cell #(
    parameter csa_pkg::carry_pol_e IN_POL = csa_pkg::CARRY_TRUE
) (
    input  logic carry_in,
    input  logic gen,
    input  logic prop,
    output logic carry_out
);

    logic t_in;
    logic t_out;

    generate
        if (IN_POL == csa_pkg::CARRY_TRUE) begin : g_aoi
            // AND-OR-invert: true carry in, complemented carry out
            assign carry_out = ~(gen | (prop & carry_in));
            assign t_in      = carry_in;
            assign t_out     = ~carry_out;
        end else begin : g_oai
            // OR-AND-invert on complemented terms: complemented in, true out
            logic ngen;
            logic nprop;
            assign ngen      = ~gen;
            assign nprop     = ~prop;
            assign carry_out = ~(ngen & (nprop | carry_in));
            assign t_in      = ~carry_in;
            assign t_out     = carry_out;
        end
    endgenerate

    always_comb begin
        if (gen) begin
            AST_SKIP_GENERATE: assert (t_out); // R4
        end
        if (!gen && prop) begin
            AST_SKIP_PASS: assert (t_out == t_in); // R5
        end
        if (!gen && !prop) begin
            AST_SKIP_KILL: assert (!t_out); // R6
        end
    end

endmodule

// File: rtl/carry_skip_adder.sv
`timescale 1ns/1ps
module carry_skip_adder #(
    parameter int WIDTH = 32,
    parameter int GROUP = 4
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int STAGES = WIDTH / GROUP;

    // Stage carries, each in the polarity csa_pkg::stage_pol gives it
    logic [STAGES-1:0] chain;

    csa_ripple_group #(.W(GROUP)) u_stage0 (
        .x     (a[GROUP-1:0]),
        .y     (b[GROUP-1:0]),
        .c_in  (cin),
        .s     (sum[GROUP-1:0]),
        .c_out (chain[0])
    );

    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_stage
            localparam csa_pkg::carry_pol_e PREV_POL = csa_pkg::stage_pol(k - 1);
            logic [GROUP-1:0] inter;
            logic             gen;
            logic             prop;
            logic             prev_true;

            csa_ripple_group #(.W(GROUP)) u_rca (
                .x     (a[k*GROUP +: GROUP]),
                .y     (b[k*GROUP +: GROUP]),
                .c_in  (1'b0),
                .s     (inter),
                .c_out (gen)
            );

            if (PREV_POL == csa_pkg::CARRY_INV) begin : g_fix
                assign prev_true = ~chain[k - 1];
            end else begin : g_keep
                assign prev_true = chain[k - 1];
            end

            csa_inc_chain #(.W(GROUP)) u_inc (
                .d       (inter),
                .inc     (prev_true),
                .q       (sum[k*GROUP +: GROUP]),
                .all_set (prop)
            );

            csa_skip_cell #(.IN_POL(PREV_POL)) u_skip (
                .carry_in  (chain[k - 1]),
                .gen       (gen),
                .prop      (prop),
                .carry_out (chain[k])
            );
        end

        if (csa_pkg::stage_pol(STAGES - 1) == csa_pkg::CARRY_INV) begin : g_out_fix
            assign cout = ~chain[STAGES - 1];
        end else begin : g_out_keep
            assign cout = chain[STAGES - 1];
        end
    endgenerate

    always_comb begin
        AST_TOTAL_SUM: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin})); // R1
        if (a == '0 && b == '0 && !cin) begin
            AST_ZERO_RESULT: assert (!cout && sum == '0); // R8
        end
    end

endmodule

// File: tb/test_carry_skip_adder.sv
`timescale 1ns/1ps
module test_carry_skip_adder;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] a32, b32, s32;
    logic        c32, o32;
    logic [7:0]  a8, b8, s8;
    logic        c8, o8;
    logic [11:0] a12, b12, s12;
    logic        c12, o12;

    carry_skip_adder i_carry_skip_adder (
        .a(a32), .b(b32), .cin(c32), .sum(s32), .cout(o32)
    );
    carry_skip_adder #(.WIDTH(8), .GROUP(4)) u_two_stage (
        .a(a8), .b(b8), .cin(c8), .sum(s8), .cout(o8)
    );
    carry_skip_adder #(.WIDTH(12), .GROUP(4)) u_three_stage (
        .a(a12), .b(b12), .cin(c12), .sum(s12), .cout(o12)
    );

    task automatic report(input string tag, input logic [32:0] act, input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk32(input string tag, input logic [31:0] x, input logic [31:0] y, input logic ci);
        logic [32:0] exp;
        a32 = x; b32 = y; c32 = ci;
        #2;
        exp = {1'b0, x} + {1'b0, y} + {32'd0, ci};
        report(tag, {o32, s32}, exp);
    endtask

    initial begin : stim
        logic [32:0] lo, hi;
        a32 = '0; b32 = '0; c32 = 1'b0;
        a8 = '0; b8 = '0; c8 = 1'b0;
        a12 = '0; b12 = '0; c12 = 1'b0;
        #5;

        chk32("R8 zero operands", 32'h0, 32'h0, 1'b0);
        chk32("R7 all ones plus one", 32'hFFFF_FFFF, 32'h0, 1'b1);
        chk32("R7 all ones plus all ones", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        chk32("R5 full propagate cin0", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
        chk32("R5 full propagate cin1", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        chk32("R4 generate in group 1", 32'h0000_0080, 32'h0000_0080, 1'b0);
        chk32("R4 generate in top group", 32'h8000_0000, 32'h8000_0000, 1'b0);
        chk32("R6 carry killed in group 1", 32'h0000_001F, 32'h0000_0001, 1'b0);
        chk32("R3 incrementer takes carry", 32'h0000_000F, 32'h0000_0001, 1'b0);
        chk32("R3 carry into middle group", 32'h00FF_FFFF, 32'h0000_0001, 1'b0);
        chk32("R1 mixed", 32'h1234_5678, 32'h8765_4321, 1'b1);

        // R2: toggling cin moves the result by exactly one
        for (int n = 0; n < 200; n++) begin
            logic [31:0] x, y;
            x = $urandom; y = $urandom;
            if (n % 4 == 0) y = ~x;
            a32 = x; b32 = y; c32 = 1'b0;
            #2 lo = {o32, s32};
            c32 = 1'b1;
            #2 hi = {o32, s32};
            report("R2 cin toggle step", hi, lo + 33'd1);
        end

        // R1: random words on the default width
        for (int n = 0; n < 2000; n++) begin
            chk32("R1 random", $urandom, $urandom, 1'($urandom));
        end

        // R9 / R1: exhaustive two-stage sweep (last skip cell is AOI)
        for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    a8 = 8'(x); b8 = 8'(y); c8 = 1'(ci);
                    #1;
                    report("R9 two-stage sweep", {24'd0, o8, s8}, 33'(x + y + ci));
                end
            end
        end

        // R9 / R1: near-exhaustive three-stage sweep (last skip cell is OAI)
        for (int x = 0; x < 4096; x++) begin
            for (int j = 0; j < 7; j++) begin
                int y;
                case (j)
                    0: y = 0;
                    1: y = 1;
                    2: y = 12'h7FF;
                    3: y = 12'hFFF;
                    4: y = 12'h555;
                    5: y = 12'hAAA;
                    default: y = 12'hF0F;
                endcase
                for (int ci = 0; ci < 2; ci++) begin
                    a12 = 12'(x); b12 = 12'(y); c12 = 1'(ci);
                    #1;
                    report("R9 three-stage sweep", {20'd0, o12, s12}, 33'(x + y + ci));
                end
            end
        end

        done = 1'b1;
    end

    initial begin : finisher
        int cycles;
        cycles = 0;
        while (!done && cycles < 150000) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule